// File: doc/BRIEF.md
# Reversible Four-Bit Look-Ahead Adder

This block adds two four-bit operands and a carry input and returns a four-bit sum and a carry output. It is built only from reversible primitives. The first is a two-input copy gate, whose second output is the XOR of its inputs. The second is a three-input controlled swap. The third is a four-input gate that works on its own as a full adder. No primitive has more than four inputs.

Each bit position has a cell that produces its propagate term, its generate term and its sum bit. A look-ahead network then builds every carry directly from the propagate terms, the generate terms and the carry input. Each carry is an XOR of mutually exclusive product terms, not a ripple from the bit below. Logic gates may not drive more than one load. Wherever a signal is needed more than once, it is duplicated through a chain of copy gates with a zero ancilla.

The block is purely combinational, with no clock and no state. It is meant as the arithmetic core of a larger reversible datapath.

Top module: `rcla_adder`

## Requirements
- R1: `sum` equals the low four bits of `op_a + op_b + carry_in`, for all 512 input combinations.
- R2: `carry_out` equals bit 4 of `op_a + op_b + carry_in`.
- R3: When every bit position propagates (`op_a + op_b == 15`), `carry_out` equals `carry_in`. `sum` is 15 when `carry_in` is 0 and 0 when `carry_in` is 1.
- R4: When bit 0 generates and bits 1 to 3 propagate (`op_a == 1`, `op_b == 15`), `carry_out` is 1 and `sum` equals `carry_in`, whatever the value of `carry_in`.
- R5: Every controlled swap passes its control input through unchanged and keeps the number of ones at its outputs equal to the number at its inputs. With the third input at zero, its second data input is routed to exactly one data output.
- R6: A copy gate whose second input is 0 gives two identical outputs equal to its source.
- R7: Within any one carry, the product terms of the look-ahead sum never overlap. This makes the XOR accumulation of the terms equal to their OR.
- R8: Every look-ahead carry c[i+1] equals g[i] XOR (p[i] AND c[i]), with c[0] being `carry_in`.
- R9: The four-input gate, with its third input held at 0, yields {carry, sum} = a + b + d. Its internal ripple carry matches g OR (p AND c) of the same cell.
- R10: The outputs follow a change at the inputs with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 4 | Four-bit sum |
| carry_out | output | 1 | Carry out of bit 3 |

## Verification
Two paths can fire in the same evaluation. One is the per-bit full-adder gate forming a sum from its incoming carry. The other is the look-ahead network forming that same carry from the propagate and generate terms of the lower bits. Driving all-propagate operands with the carry input toggled makes both paths switch at once across every bit. The sum and the carry output are then compared with an independent integer addition. The exhaustive sweep covers every mix of generate, propagate and kill patterns. Within each cell, the gate's own ripple carry is compared against the look-ahead form.

// File: rtl/rcla_pkg.sv
package rcla_pkg;

  // number of copies of propagate bit i needed by a width-w look-ahead
  function automatic int p_uses(int w, int i);
    return (w - i) * (i + 1);
  endfunction

  function automatic int p_base(int w, int i);
    int acc;
    acc = 0;
    for (int m = 0; m < i; m++) acc += p_uses(w, m);
    return acc;
  endfunction

  // number of copies of generate bit k
  function automatic int g_uses(int w, int k);
    return w - k;
  endfunction

  function automatic int g_base(int w, int k);
    int acc;
    acc = 0;
    for (int m = 0; m < k; m++) acc += g_uses(w, m);
    return acc;
  endfunction

endpackage

// File: rtl/rev_copy.sv
module rev_copy (
  input  logic src,
  input  logic anc,
  output logic thru,
  output logic dup
);
  always_comb begin
    thru = src;
    dup  = src ^ anc;
  end

  // copy mode: both outputs carry the same value
  always_comb begin
    if (anc == 1'b0) begin
      assert_copy_twin_R6: assert (dup == thru);
    end
  end
endmodule

// File: rtl/rev_swap.sv
module rev_swap (
  input  logic ctl,
  input  logic x2,
  input  logic x3,
  output logic y1,
  output logic y2,
  output logic y3
);
  always_comb begin
    y1 = ctl;
    y2 = ctl ? x3 : x2;
    y3 = ctl ? x2 : x3;
  end

  always_comb begin
    assert_swap_weight_R5: assert ($countones({ctl, x2, x3}) == $countones({y1, y2, y3}));
  end
endmodule

// File: rtl/rev_fa4.sv
module rev_fa4 (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic p,
  output logic q,
  output logic r,
  output logic s
);
  always_comb begin
    p = a;
    q = (~a & ~c) ^ ~b;
    r = q ^ d;
    s = (q & d) ^ ((a & b) ^ c);
  end

  always_comb begin
    if (c == 1'b0) begin
      assert_fa_count_R9: assert ({s, r} == ({1'b0, a} + {1'b0, b} + {1'b0, d}));
    end
  end
endmodule

// File: rtl/rev_fanout.sv
module rev_fanout #(
  parameter int COPIES = 2
) (
  input  logic              x,
  output logic [COPIES-1:0] y
);
  generate
    if (COPIES == 1) begin : g_single
      assign y[0] = x;
    end else begin : g_chain
      logic [COPIES-1:0] chain;
      assign chain[0] = x;
      for (genvar i = 0; i < COPIES - 1; i++) begin : g_cp
        rev_copy u_cp (
          .src (chain[i]),
          .anc (1'b0),
          .thru(chain[i+1]),
          .dup (y[i])
        );
      end
      assign y[COPIES-1] = chain[COPIES-1];
    end
  endgenerate
endmodule

// File: rtl/rev_pgs_cell.sv
module rev_pgs_cell (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic p,
  output logic g,
  output logic s
);
  logic b0, b1;
  logic a_thru, fa_carry;
  logic sw_ctl, sw_off;

  rev_copy u_bcp (
    .src (b),
    .anc (1'b0),
    .thru(b0),
    .dup (b1)
  );

  rev_fa4 u_fa (
    .a(a),
    .b(b0),
    .c(1'b0),
    .d(cin),
    .p(a_thru),
    .q(p),
    .r(s),
    .s(fa_carry)
  );

  rev_swap u_gen (
    .ctl(a_thru),
    .x2 (b1),
    .x3 (1'b0),
    .y1 (sw_ctl),
    .y2 (sw_off),
    .y3 (g)
  );

  always_comb begin
    assert_cell_carry_R9: assert (fa_carry == (g | (p & cin)));
    assert_cell_route_R5: assert (((sw_off ^ g) == b1) && (sw_ctl == a));
  end
endmodule

// File: rtl/rev_lookahead.sv
module rev_lookahead
  import rcla_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  input  logic         c0,
  output logic [W-1:0] cell_cin,
  output logic         cout
);
  localparam int PT = p_base(W, W);
  localparam int GT = g_base(W, W);

  logic [PT-1:0] pc;
  logic [GT-1:0] gc;
  logic [W:0]    c0c;
  logic [W:0]    carry;

  generate
    for (genvar i = 0; i < W; i++) begin : g_fan
      rev_fanout #(.COPIES(p_uses(W, i))) u_pfan (
        .x(p[i]),
        .y(pc[p_base(W, i) +: p_uses(W, i)])
      );
      rev_fanout #(.COPIES(g_uses(W, i))) u_gfan (
        .x(g[i]),
        .y(gc[g_base(W, i) +: g_uses(W, i)])
      );
    end
  endgenerate

  rev_fanout #(.COPIES(W + 1)) u_cfan (
    .x(c0),
    .y(c0c)
  );

  generate
    for (genvar j = 0; j < W; j++) begin : g_carry
      logic [j+1:0] term;
      logic [j+1:0] xacc;

      // term t: (t==0 ? c0 : g[t-1]) AND p[t] .. p[j]
      for (genvar t = 0; t <= j + 1; t++) begin : g_term
        localparam int LEN = j - t + 1;
        logic [LEN:0] acc;
        if (t == 0) begin : g_src_c
          assign acc[0] = c0c[j];
        end else begin : g_src_g
          assign acc[0] = gc[g_base(W, t - 1) + (j - (t - 1))];
        end
        for (genvar s = 0; s < LEN; s++) begin : g_and
          localparam int PI   = t + s;
          localparam int PIDX = p_base(W, PI) + (j - PI) * (PI + 1) + t;
          logic gb_ctl, gb_off;
          rev_swap u_and (
            .ctl(pc[PIDX]),
            .x2 (acc[s]),
            .x3 (1'b0),
            .y1 (gb_ctl),
            .y2 (gb_off),
            .y3 (acc[s+1])
          );
          always_comb begin
            assert_and_route_R5: assert (((gb_off ^ acc[s+1]) == acc[s]) && (gb_ctl == pc[PIDX]));
          end
        end
        assign term[t] = acc[LEN];
      end

      assign xacc[0] = term[0];
      for (genvar t = 1; t <= j + 1; t++) begin : g_xor
        logic gb_prev;
        rev_copy u_x (
          .src (xacc[t-1]),
          .anc (term[t]),
          .thru(gb_prev),
          .dup (xacc[t])
        );
        always_comb begin
          assert_terms_disjoint_R7: assert (!(gb_prev && term[t]));
        end
      end
      assign carry[j+1] = xacc[j+1];
    end
  endgenerate

  assign carry[0]  = c0c[W];
  assign cell_cin  = carry[W-1:0];
  assign cout      = carry[W];

  always_comb begin
    for (int j = 0; j < W; j++) begin
      assert_carry_recur_R8: assert (carry[j+1] == (g[j] ^ (p[j] & carry[j])));
    end
  end
endmodule

// File: rtl/rcla_adder.sv
module rcla_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W-1:0] cin_v;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      rev_pgs_cell u_cell (
        .a  (op_a[i]),
        .b  (op_b[i]),
        .cin(cin_v[i]),
        .p  (prop[i]),
        .g  (gen[i]),
        .s  (sum[i])
      );
    end
  endgenerate

  rev_lookahead #(.W(W)) u_la (
    .p       (prop),
    .g       (gen),
    .c0      (carry_in),
    .cell_cin(cin_v),
    .cout    (carry_out)
  );
endmodule

// File: tb/rcla_adder_bench.sv
module rcla_adder_bench;
  logic       clk;
  logic [3:0] op_a, op_b;
  logic       carry_in;
  logic [3:0] sum;
  logic       carry_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // {a[13:10], b[9:6], cin[5], expected {cout,sum}[4:0]}
  localparam logic [13:0] VEC [9] = '{
    14'b0000_0000_0_00000,
    14'b1111_0000_1_10000,
    14'b1111_1111_1_11111,
    14'b1111_1111_0_11110,
    14'b0001_1111_0_10000,
    14'b1010_0101_0_01111,
    14'b1010_0101_1_10000,
    14'b1000_1000_0_10000,
    14'b1001_0110_1_10000
  };

  rcla_adder u_rcla_adder (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum      (sum),
    .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d cin=%0d got=%0d expected=%0d",
               tag, op_a, op_b, carry_in, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic c);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    op_a = '0; op_b = '0; carry_in = 1'b0;
    #1;
    // R10: zero inputs give zero outputs before any clock edge
    check("R10 idle", {carry_out, sum}, 5'd0);

    for (int v = 0; v < 9; v++) begin
      apply(VEC[v][13:10], VEC[v][9:6], VEC[v][5]);
      check("R1/R2 table", {carry_out, sum}, VEC[v][4:0]);
    end

    // exhaustive sweep against an integer sum; exercises R5 R6 R7 R8 R9
    for (int k = 0; k < 512; k++) begin
      logic [4:0] ref_v;
      apply(k[8:5], k[4:1], k[0]);
      ref_v = {1'b0, k[8:5]} + {1'b0, k[4:1]} + {4'b0, k[0]};
      check("R1 sum", {1'b0, sum}, {1'b0, ref_v[3:0]});
      check("R2 carry_out", {4'b0, carry_out}, {4'b0, ref_v[4]});
    end

    // R3: full propagate chain, carry_in toggled
    apply(4'd7, 4'd8, 1'b0);
    check("R3 propagate cin0", {carry_out, sum}, 5'd15);
    apply(4'd7, 4'd8, 1'b1);
    check("R3 propagate cin1", {carry_out, sum}, 5'd16);
    apply(4'd12, 4'd3, 1'b1);
    check("R3 propagate cin1", {carry_out, sum}, 5'd16);

    // R4: generate at bit 0, propagate above
    apply(4'd1, 4'd15, 1'b0);
    check("R4 generate cin0", {carry_out, sum}, 5'd16);
    apply(4'd1, 4'd15, 1'b1);
    check("R4 generate cin1", {carry_out, sum}, 5'd17);

    // R10: output follows input change without waiting for a clock edge
    @(negedge clk);
    op_a = 4'd6; op_b = 4'd9; carry_in = 1'b0;
    #1;
    check("R10 same cycle", {carry_out, sum}, 5'd15);
    carry_in = 1'b1;
    #0.5;
    check("R10 same cycle", {carry_out, sum}, 5'd16);

    finish_run();
  end
endmodule